// File: doc/BRIEF.md
# Vector Even/Odd Element Unzip Unit

This unit takes two source vectors and packs either their even-numbered or their odd-numbered elements into one destination vector. Elements picked from the first source fill the low part of the result. Elements picked from the second source follow directly above them. Three things are chosen per operation, at run time: the element width, the parity and the active vector length. The boundary between the two halves therefore moves with the length, and every result bit above the packed region is zero.

A request is presented with a valid strobe. One clock later the unit returns either the packed result with an output valid, or an illegal flag when the length does not suit the requested element width. Source bits at or above the active length never reach the result. The maximum vector length is the parameter `MAXVL`. Active lengths are multiples of 128 bits.

Top module: `vuzp_unit`

## Requirements
- R1: Element width follows the 2-bit size code: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. With `quad_mode` high the width is 128 bits and the size code is ignored.
- R2: With `odd_sel` low, output pair index p takes source element 2p. With `odd_sel` high it takes source element 2p+1.
- R3: Let pairs = vec_len / (2 × width), using integer division. Result elements 0 to pairs-1 are the selected elements of `src_a`, in ascending order.
- R4: Result elements pairs to 2×pairs-1 are the selected elements of `src_b`, in ascending order.
- R5: Every result bit at or above 2 × pairs × width is zero. This includes quadword mode with a length that is an odd multiple of 128.
- R6: Source bits at or above `vec_len` have no effect on the result.
- R7: A request is illegal, and raises `out_illegal` with `out_valid` low, when `vec_len` is zero, is not a multiple of 128, or exceeds `MAXVL`.
- R8: In quadword mode a `vec_len` below 256 is illegal.
- R9: Latency is one clock. `out_valid` is high exactly in the cycle after a legal request with `in_valid` high.
- R10: `result` keeps its previous value after an illegal request or an idle cycle. `out_valid` and `out_illegal` are low after a cycle with `in_valid` low.
- R11: During reset, `out_valid`, `out_illegal` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| size_code | input | 2 | Element width code (8 << code bits) |
| odd_sel | input | 1 | 0 selects even elements, 1 selects odd elements |
| quad_mode | input | 1 | Forces 128-bit elements |
| vec_len | input | $clog2(MAXVL+1) | Active vector length in bits |
| src_a | input | MAXVL | First source vector |
| src_b | input | MAXVL | Second source vector |
| out_valid | output | 1 | Result valid, one cycle after a legal request |
| out_illegal | output | 1 | Request was illegal for its length and width |
| result | output | MAXVL | Packed destination vector |

## Verification
Two functions act in the same cycle: ignoring source bits above the active length, and forcing the tail of the result to zero. The bench fills every source bit above `vec_len` with random data. It computes the expected value from copies of the sources with those bits cleared. It then checks three regions of the result separately: the low region, the high region and the zero tail. Quadword requests with lengths of 384, 640 and other odd multiples of 128 are where both functions bite hardest. In those cases live but ignored source bits sit right next to a zero-filled gap of 128 bits.

// File: rtl/vuzp_pkg.sv
package vuzp_pkg;
  localparam int unsigned LANE_W  = 64;  // pack shifter granule in bits
  localparam int unsigned GRAN_LG = 7;   // active lengths are multiples of 2**GRAN_LG
  localparam int unsigned QUAD_LG = 8;   // quadword pair size is 2**QUAD_LG bits
  localparam int unsigned NSIZES  = 5;   // 8,16,32,64,128-bit element variants

  typedef enum logic [2:0] {
    EW_8   = 3'd0,
    EW_16  = 3'd1,
    EW_32  = 3'd2,
    EW_64  = 3'd3,
    EW_128 = 3'd4
  } elem_w_e;
endpackage

// File: rtl/vuzp_compact.sv
// Packs the even or odd elements of one source into the lower half,
// using fixed wiring for every element width and a final width select.
module vuzp_compact
  import vuzp_pkg::*;
#(
  parameter int unsigned MAXVL = 2048
) (
  input  logic [MAXVL-1:0]   src,
  input  logic               odd_sel,
  input  elem_w_e            width_sel,
  output logic [MAXVL/2-1:0] packed_o
);
  localparam int unsigned HALF = MAXVL / 2;

  logic [HALF-1:0] cand [NSIZES];

  for (genvar g = 0; g < NSIZES; g++) begin : g_width
    localparam int unsigned EW = 8 << g;
    localparam int unsigned NH = MAXVL / (2 * EW);
    logic [HALF-1:0] even_w;
    logic [HALF-1:0] odd_w;
    for (genvar k = 0; k < NH; k++) begin : g_elem
      assign even_w[k*EW +: EW] = src[(2*k)*EW   +: EW];
      assign odd_w [k*EW +: EW] = src[(2*k+1)*EW +: EW];
    end
    assign cand[g] = odd_sel ? odd_w : even_w;
  end

  always_comb begin
    case (width_sel)
      EW_8:    packed_o = cand[0];
      EW_16:   packed_o = cand[1];
      EW_32:   packed_o = cand[2];
      EW_64:   packed_o = cand[3];
      default: packed_o = cand[4];
    endcase
  end
endmodule

// File: rtl/vuzp_len_check.sv
// Legality of the active length, and the size of each packed half in 64-bit words.
module vuzp_len_check
  import vuzp_pkg::*;
#(
  parameter int unsigned MAXVL = 2048,
  localparam int unsigned LENW = $clog2(MAXVL + 1),
  localparam int unsigned HWW  = $clog2(MAXVL / LANE_W)
) (
  input  logic [LENW-1:0] vec_len,
  input  logic            quad_mode,
  output logic            legal,
  output logic [HWW-1:0]  half_words
);
  logic gran_ok;
  logic nonzero;
  logic in_range;
  logic quad_ok;

  always_comb begin
    gran_ok  = (vec_len[GRAN_LG-1:0] == '0);
    nonzero  = (vec_len != '0);
    in_range = (vec_len <= LENW'(MAXVL));
    quad_ok  = !quad_mode || (vec_len >= LENW'(2**QUAD_LG));
    legal    = gran_ok && nonzero && in_range && quad_ok;
    // half = pairs*width bits: len/2 for narrow elements, floor(len/256)*128 for quadwords
    if (quad_mode) half_words = HWW'((vec_len >> QUAD_LG) << 1);
    else           half_words = HWW'(vec_len >> GRAN_LG);
  end
endmodule

// File: rtl/vuzp_pack.sv
// Masks both compacted halves to the packed length, then lifts the
// second one above the first with a word-granular logarithmic shifter.
module vuzp_pack
  import vuzp_pkg::*;
#(
  parameter int unsigned MAXVL = 2048,
  localparam int unsigned HALF = MAXVL / 2,
  localparam int unsigned NW   = MAXVL / LANE_W,
  localparam int unsigned HWW  = $clog2(NW)
) (
  input  logic [HALF-1:0]  lo_c,
  input  logic [HALF-1:0]  hi_c,
  input  logic [HWW-1:0]   half_words,
  output logic [MAXVL-1:0] packed_o
);
  logic [HALF-1:0]  lo_m;
  logic [HALF-1:0]  hi_m;
  logic [MAXVL-1:0] stg [HWW+1];

  for (genvar w = 0; w < NW / 2; w++) begin : g_mask
    logic keep;
    assign keep = (HWW'(w) < half_words);
    assign lo_m[w*LANE_W +: LANE_W] = keep ? lo_c[w*LANE_W +: LANE_W] : '0;
    assign hi_m[w*LANE_W +: LANE_W] = keep ? hi_c[w*LANE_W +: LANE_W] : '0;
  end

  assign stg[0] = {{HALF{1'b0}}, hi_m};
  for (genvar s = 0; s < HWW; s++) begin : g_shift
    assign stg[s+1] = half_words[s] ? (stg[s] << (LANE_W << s)) : stg[s];
  end

  assign packed_o = stg[HWW] | {{HALF{1'b0}}, lo_m};
endmodule

// File: rtl/vuzp_unit.sv
module vuzp_unit
  import vuzp_pkg::*;
#(
  parameter int unsigned MAXVL = 2048,
  localparam int unsigned LENW = $clog2(MAXVL + 1),
  localparam int unsigned HALF = MAXVL / 2,
  localparam int unsigned HWW  = $clog2(MAXVL / LANE_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       size_code,
  input  logic             odd_sel,
  input  logic             quad_mode,
  input  logic [LENW-1:0]  vec_len,
  input  logic [MAXVL-1:0] src_a,
  input  logic [MAXVL-1:0] src_b,
  output logic             out_valid,
  output logic             out_illegal,
  output logic [MAXVL-1:0] result
);
  elem_w_e          width_sel;
  logic [HALF-1:0]  comp_a;
  logic [HALF-1:0]  comp_b;
  logic             legal;
  logic [HWW-1:0]   half_words;
  logic [MAXVL-1:0] packed_w;

  logic             load_en;
  logic             valid_d,   valid_q;
  logic             illegal_d, illegal_q;
  logic [MAXVL-1:0] result_d,  result_q;

  assign width_sel = quad_mode ? EW_128 : elem_w_e'({1'b0, size_code});

  vuzp_compact #(.MAXVL(MAXVL)) u_comp_a (
    .src(src_a), .odd_sel(odd_sel), .width_sel(width_sel), .packed_o(comp_a)
  );
  vuzp_compact #(.MAXVL(MAXVL)) u_comp_b (
    .src(src_b), .odd_sel(odd_sel), .width_sel(width_sel), .packed_o(comp_b)
  );
  vuzp_len_check #(.MAXVL(MAXVL)) u_len (
    .vec_len(vec_len), .quad_mode(quad_mode), .legal(legal), .half_words(half_words)
  );
  vuzp_pack #(.MAXVL(MAXVL)) u_pack (
    .lo_c(comp_a), .hi_c(comp_b), .half_words(half_words), .packed_o(packed_w)
  );

  always_comb begin
    load_en   = in_valid && legal;
    valid_d   = load_en;
    illegal_d = in_valid && !legal;
    result_d  = load_en ? packed_w : result_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
      result_q  <= '0;
    end else begin
      valid_q   <= valid_d;
      illegal_q <= illegal_d;
      result_q  <= result_d;
    end
  end

  assign out_valid   = valid_q;
  assign out_illegal = illegal_q;
  assign result      = result_q;
endmodule

module vuzp_unit_chk #(
  parameter int unsigned MAXVL = 2048,
  localparam int unsigned LENW = $clog2(MAXVL + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             quad_mode,
  input logic [LENW-1:0]  vec_len,
  input logic             out_valid,
  input logic             out_illegal,
  input logic [MAXVL-1:0] result
);
  // R7: a response is never both valid and illegal
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_illegal));

  // R7: lengths off the 128-bit granule are rejected
  a_r7_granule: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && vec_len[6:0] != 7'd0) |=> (out_illegal && !out_valid));

  // R8: quadword mode needs at least 256 bits
  a_r8_quad_min: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && quad_mode && vec_len < LENW'(256)) |=> out_illegal);

  // R9: every request gets exactly one kind of answer next cycle
  a_r9_answer: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_valid || out_illegal));

  // R10: idle cycle gives no response
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_illegal));

  // R10: result only changes when a valid result is presented
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(result));

  // R5: nothing above the active length
  a_r5_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((result >> $past(vec_len)) == '0));

  // R5: quadword results stop at the last whole 256-bit pair
  a_r5_quad_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(quad_mode)) |->
      ((result >> {$past(vec_len) >> 8, 8'b0}) == '0));
endmodule

bind vuzp_unit vuzp_unit_chk #(.MAXVL(MAXVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .quad_mode(quad_mode),
  .vec_len(vec_len), .out_valid(out_valid), .out_illegal(out_illegal),
  .result(result)
);

// File: tb/vuzp_unit_test.sv
module vuzp_unit_test;
  localparam int MAXVL = 2048;
  localparam int LENW  = $clog2(MAXVL + 1);
  typedef logic [MAXVL-1:0] vec_t;

  logic            clk;
  logic            rst_n;
  logic            in_valid;
  logic [1:0]      size_code;
  logic            odd_sel;
  logic            quad_mode;
  logic [LENW-1:0] vec_len;
  vec_t            src_a, src_b;
  logic            out_valid, out_illegal;
  vec_t            result;

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 0;
  vec_t last_res;

  vuzp_unit #(.MAXVL(MAXVL)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_code(size_code),
    .odd_sel(odd_sel), .quad_mode(quad_mode), .vec_len(vec_len),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
    .out_illegal(out_illegal), .result(result)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input vec_t act, input vec_t exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic vec_t rnd_vec();
    vec_t v;
    for (int i = 0; i < MAXVL / 32; i++) v[i*32 +: 32] = $urandom();
    return v;
  endfunction

  function automatic vec_t clear_above(input vec_t v, input int vl);
    for (int i = 0; i < MAXVL; i++) if (i >= vl) v[i] = 1'b0;
    return v;
  endfunction

  function automatic int ewidth(input logic [1:0] code, input logic q);
    return q ? 128 : (8 << code);
  endfunction

  function automatic bit is_legal(input int vl, input logic q);
    return (vl % 128 == 0) && vl >= 128 && vl <= MAXVL && !(q && vl < 256);
  endfunction

  function automatic vec_t model(input vec_t a, input vec_t b, input logic [1:0] code,
                                 input logic odd, input logic q, input int vl);
    vec_t r = '0;
    int e = ewidth(code, q);
    int pairs = vl / (2 * e);
    for (int p = 0; p < pairs; p++)
      for (int j = 0; j < e; j++) begin
        r[p*e + j]         = a[(2*p + odd)*e + j];
        r[(pairs+p)*e + j] = b[(2*p + odd)*e + j];
      end
    return r;
  endfunction

  function automatic vec_t region(input int lo, input int hi);
    vec_t m = '0;
    for (int i = 0; i < MAXVL; i++) if (i >= lo && i < hi) m[i] = 1'b1;
    return m;
  endfunction

  task automatic run_op(input logic v, input logic [1:0] code, input logic odd,
                        input logic q, input int vl, input vec_t a, input vec_t b,
                        input string tag);
    bit   lg;
    vec_t exp;
    vec_t lo_m, hi_m;
    int   e, pe;
    @(negedge clk);
    in_valid = v; size_code = code; odd_sel = odd; quad_mode = q;
    vec_len = LENW'(vl); src_a = a; src_b = b;
    @(posedge clk);
    #1;
    lg = is_legal(vl, q);
    chk($sformatf("R9 out_valid %s", tag), vec_t'(out_valid), vec_t'(v && lg));
    if (q && vl < 256 && vl % 128 == 0 && vl > 0)
      chk($sformatf("R8 quad short %s", tag), vec_t'(out_illegal), vec_t'(v));
    else
      chk($sformatf("R7 illegal %s", tag), vec_t'(out_illegal), vec_t'(v && !lg));
    if (v && lg) begin
      // R6: expected value built from sources with bits above vl cleared
      exp  = model(clear_above(a, vl), clear_above(b, vl), code, odd, q, vl);
      e    = ewidth(code, q);
      pe   = (vl / (2 * e)) * e;
      lo_m = region(0, pe);
      hi_m = region(pe, 2 * pe);
      chk($sformatf("R3 low part %s", tag),  result & lo_m, exp & lo_m);
      chk($sformatf("R4 high part %s", tag), result & hi_m, exp & hi_m);
      chk($sformatf("R5 zero tail %s", tag), result & ~(lo_m | hi_m), '0);
      chk($sformatf("R1 R2 R6 full %s", tag), result, exp);
      last_res = exp;
    end else begin
      chk($sformatf("R10 hold %s", tag), result, last_res);
    end
  endtask

  initial begin
    vec_t a, b;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; size_code = '0; odd_sel = 1'b0;
    quad_mode = 1'b0; vec_len = '0; src_a = '0; src_b = '0;
    #7;
    chk("R11 reset out_valid", vec_t'(out_valid), '0);
    chk("R11 reset out_illegal", vec_t'(out_illegal), '0);
    chk("R11 reset result", result, '0);
    last_res = '0;
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2: every width and parity at full and minimal length
    for (int c = 0; c < 4; c++)
      for (int o = 0; o < 2; o++) begin
        run_op(1'b1, 2'(c), 1'(o), 1'b0, MAXVL, rnd_vec(), rnd_vec(), "R1 R2 full len");
        run_op(1'b1, 2'(c), 1'(o), 1'b0, 128,   rnd_vec(), rnd_vec(), "R1 R2 min len");
      end
    // R5 R8: quadword mode lengths
    for (int o = 0; o < 2; o++) begin
      run_op(1'b1, 2'd0, 1'(o), 1'b1, 256, rnd_vec(), rnd_vec(), "R8 quad 256");
      run_op(1'b1, 2'd2, 1'(o), 1'b1, 384, rnd_vec(), rnd_vec(), "R5 quad 384");
      run_op(1'b1, 2'd1, 1'(o), 1'b1, 128, rnd_vec(), rnd_vec(), "R8 quad 128");
      run_op(1'b1, 2'd3, 1'(o), 1'b1, 1920, rnd_vec(), rnd_vec(), "R5 quad 1920");
    end
    // R7: illegal lengths
    run_op(1'b1, 2'd0, 1'b0, 1'b0, 0,    rnd_vec(), rnd_vec(), "R7 zero");
    run_op(1'b1, 2'd1, 1'b1, 1'b0, 100,  rnd_vec(), rnd_vec(), "R7 off granule");
    run_op(1'b1, 2'd2, 1'b0, 1'b0, MAXVL + 128, rnd_vec(), rnd_vec(), "R7 over max");
    run_op(1'b1, 2'd3, 1'b1, 1'b0, 4095, rnd_vec(), rnd_vec(), "R7 all ones");
    // R6: same request, different junk above the length
    a = rnd_vec(); b = rnd_vec();
    run_op(1'b1, 2'd0, 1'b1, 1'b0, 640, a, b, "R6 junk A");
    run_op(1'b1, 2'd0, 1'b1, 1'b0, 640, clear_above(a, 640) | (rnd_vec() & ~region(0, 640)),
           clear_above(b, 640) | (rnd_vec() & ~region(0, 640)), "R6 junk B");
    // R10: idle after a legal result
    run_op(1'b0, 2'd1, 1'b0, 1'b0, 512, rnd_vec(), rnd_vec(), "R10 idle");

    // constrained random mix
    for (int i = 0; i < 240; i++) begin
      logic v, q;
      int vl;
      v  = ($urandom() % 8) != 0;
      q  = ($urandom() % 5) == 0;
      if (($urandom() % 4) != 0) vl = (1 + $urandom() % (MAXVL / 128)) * 128;
      else                       vl = $urandom() % 4096;
      run_op(v, 2'($urandom()), 1'($urandom()), q, vl, rnd_vec(), rnd_vec(), "R6 random");
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule